// File: doc/BRIEF.md
# Collision Jam and Retry Controller

This block decides how one transmit attempt ends when the medium reports a collision, and it keeps the retry record for the frame being sent. The transmit datapath tells it three things: whether it is still sending the preamble and start delimiter, how many data bits have gone out since then, and whether a transmission is in progress. From these it picks the response to a collision. A collision during the preamble waits for the preamble to finish before the jam starts. A collision inside the slot window starts the jam at once. A collision after the slot window is treated as late.

After a jam that still allows a retry, the block raises a reschedule request. It holds the request until an external backoff delay unit answers with backoff-done, and then re-arms for the next attempt. The block counts retries, stops a frame once its attempt budget is used up, and reports a final status with a one-cycle done strobe. The status says whether the frame needed one retry, several retries, ran out of retries, or was abandoned after a late collision. When the frame is given up because of collisions, the block also asks for the frame to be discarded.

Top module: `coll_retry_ctrl`

## Requirements
- R1: A collision seen while `pre_phase` is high does not start the jam. `jam_on` stays low until the first clock edge at which `pre_phase` is low, and it rises in the cycle after that edge.
- R2: A collision seen with `pre_phase` low and `data_bits` below 512 starts the jam at once. `jam_on` and `tx_abort` are high in the cycle after the collision is sampled.
- R3: A jam lasts exactly 32 consecutive cycles of `jam_on`, one all-zero bit per cycle. `tx_abort` is high only in the first of those cycles.
- R4: Each collision that is not late adds one to `retry_cnt`. After a jam that still permits a retry, `resched_req` stays high until `backoff_done` is sampled high, and the block then accepts the next attempt.
- R5: A frame gets at most 16 attempts. When the 16th attempt collides, `retry_cnt` stays at 15, no reschedule follows the jam, and the done cycle shows `st_rtry`=1, `st_one`=0, `st_more`=0 and `flush_req`=1.
- R6: A frame that ends through `tx_end` reports `st_one`=1 when `retry_cnt` is 1, reports `st_more`=1 when `retry_cnt` is greater than 1, and reports neither when `retry_cnt` is 0.
- R7: If `retry_dis` is high when the first collision is sampled, the frame ends after that jam with only `st_rtry` set and with `flush_req`=1.
- R8: A collision with `pre_phase` low and `data_bits` of 512 or more is late. It leaves `retry_cnt` unchanged, is jammed, and ends the frame with `st_late`=1, `st_rtry`=0 and `flush_req`=0.
- R9: A `frame_start` pulse clears `retry_cnt` and all status bits by the next cycle.
- R10: `done_stb` is high for exactly one cycle per frame. The status bits hold their values after that cycle until the next `frame_start`.
- R11: A collision is ignored unless the block is armed for an attempt and `tx_on` is high. An ignored collision leaves `jam_on`, `retry_cnt` and the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse: a new frame begins, arms the first attempt |
| tx_on | input | 1 | A transmission is in progress |
| pre_phase | input | 1 | Preamble and start delimiter still being sent |
| data_bits | input | DBW (10) | Bits sent since the start delimiter |
| coll_det | input | 1 | Collision detected |
| retry_dis | input | 1 | Abandon the frame at its first collision |
| tx_end | input | 1 | Pulse: the attempt finished without a collision |
| backoff_done | input | 1 | The backoff delay has expired |
| jam_on | output | 1 | Insert a jam bit (value zero) this cycle |
| tx_abort | output | 1 | Pulse: stop sending frame data |
| resched_req | output | 1 | Request a backoff before the next attempt |
| flush_req | output | 1 | Pulse: discard the frame |
| done_stb | output | 1 | Pulse: the frame status is final |
| st_one | output | 1 | Exactly one retry was needed |
| st_more | output | 1 | More than one retry was needed |
| st_rtry | output | 1 | Retries exhausted or disabled |
| st_late | output | 1 | Frame ended by a late collision |
| retry_cnt | output | CW (4) | Retries so far; attempts equal this plus one |

## Verification
Every response is registered once. A collision in the slot window shows on `jam_on`, `tx_abort` and `retry_cnt` one cycle after the edge that samples it. A preamble collision shows one cycle after the first edge that sees `pre_phase` low. `done_stb`, the status bits and `flush_req` appear one cycle after `tx_end`, or in the first cycle after the last jam cycle, and `resched_req` appears in that same cycle instead when a retry follows. The bench drives inputs on falling edges and samples on the next falling edge, so each check lands in the cycle where its result is due. It counts jam cycles one falling edge at a time, and it checks the status again one cycle after the done strobe to confirm that the status holds.

// File: rtl/coll_retry_pkg.sv
package coll_retry_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARMED,
      ST_PEND,
      ST_JAM,
      ST_BACKOFF,
      ST_FINAL
   } cr_state_e;

   typedef enum logic [1:0] {
      CL_PRE,
      CL_SLOT,
      CL_LATE
   } coll_cls_e;

endpackage

// File: rtl/coll_phase_class.sv
module coll_phase_class
   import coll_retry_pkg::*;
#(
   parameter int SLOT_BITS = 512,
   parameter int DBW       = 10
) (
   input  logic           pre_phase,
   input  logic [DBW-1:0] data_bits,
   output coll_cls_e      cls
);

   localparam logic [DBW-1:0] SLOT_LIM = DBW'(SLOT_BITS);

   always_comb begin
      if (pre_phase)
         cls = CL_PRE;
      else if (data_bits >= SLOT_LIM)
         cls = CL_LATE;
      else
         cls = CL_SLOT;
   end

endmodule

// File: rtl/jam_timer.sv
module jam_timer #(
   parameter int JAM_BITS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic first,
   output logic last
);

   localparam int JW = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
   localparam logic [JW-1:0] LAST_IDX = JW'(JAM_BITS - 1);

   logic [JW-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (busy) begin
         if (idx == LAST_IDX) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign first = busy && (idx == '0);
   assign last  = busy && (idx == LAST_IDX);

   // R3: a running jam does not stop before its final bit
   a_r3_jam_no_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !last |=> busy);

   // R3: a jam only ends right after its final bit
   a_r3_jam_ends_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(last));

endmodule

// File: rtl/retry_acct.sv
module retry_acct #(
   parameter int MAX_ATTEMPTS = 16,
   parameter int CW           = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          hit,
   output logic [CW-1:0] cnt,
   output logic          exhausted
);

   localparam logic [CW-1:0] CNT_MAX = CW'(MAX_ATTEMPTS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt       <= '0;
         exhausted <= 1'b0;
      end else if (hit) begin
         if (cnt == CNT_MAX)
            exhausted <= 1'b1;
         else
            cnt <= cnt + 1'b1;
      end
   end

   // R4: the count only ever steps up by one or returns to zero
   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1) || (cnt == '0));

   // R5: the budget is spent only from the top count
   a_r5_exhaust_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exhausted) |-> cnt == CNT_MAX);

endmodule

// File: rtl/coll_retry_ctrl.sv
module coll_retry_ctrl
   import coll_retry_pkg::*;
#(
   parameter int SLOT_BITS    = 512,
   parameter int DBW          = $clog2(SLOT_BITS) + 1,
   parameter int JAM_BITS     = 32,
   parameter int MAX_ATTEMPTS = 16,
   parameter int CW           = $clog2(MAX_ATTEMPTS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           frame_start,
   input  logic           tx_on,
   input  logic           pre_phase,
   input  logic [DBW-1:0] data_bits,
   input  logic           coll_det,
   input  logic           retry_dis,
   input  logic           tx_end,
   input  logic           backoff_done,
   output logic           jam_on,
   output logic           tx_abort,
   output logic           resched_req,
   output logic           flush_req,
   output logic           done_stb,
   output logic           st_one,
   output logic           st_more,
   output logic           st_rtry,
   output logic           st_late,
   output logic [CW-1:0]  retry_cnt
);

   // elaboration-time parameter checks
   generate
      if (SLOT_BITS >= (1 << DBW)) begin : g_bad_dbw
         $error("DBW too narrow for SLOT_BITS");
      end
      if ((MAX_ATTEMPTS < 2) || ((MAX_ATTEMPTS - 1) >= (1 << CW))) begin : g_bad_cw
         $error("CW does not fit MAX_ATTEMPTS");
      end
      if (JAM_BITS < 2) begin : g_bad_jam
         $error("JAM_BITS must be at least 2");
      end
   endgenerate

   cr_state_e st;
   coll_cls_e cls;
   logic      accept, hit, jam_start;
   logic      jam_busy, jam_first, jam_last;
   logic      exhausted, dis_r, late_r;

   coll_phase_class #(.SLOT_BITS(SLOT_BITS), .DBW(DBW)) u_class (
      .pre_phase (pre_phase),
      .data_bits (data_bits),
      .cls       (cls)
   );

   assign accept    = (st == ST_ARMED) && tx_on && coll_det && !frame_start;
   assign hit       = accept && (cls != CL_LATE);
   assign jam_start = (accept && (cls != CL_PRE)) ||
                      ((st == ST_PEND) && !pre_phase && !frame_start);

   jam_timer #(.JAM_BITS(JAM_BITS)) u_jam (
      .clk   (clk),
      .rst_n (rst_n),
      .start (jam_start),
      .busy  (jam_busy),
      .first (jam_first),
      .last  (jam_last)
   );

   retry_acct #(.MAX_ATTEMPTS(MAX_ATTEMPTS), .CW(CW)) u_acct (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (frame_start),
      .hit       (hit),
      .cnt       (retry_cnt),
      .exhausted (exhausted)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         dis_r   <= 1'b0;
         late_r  <= 1'b0;
         st_one  <= 1'b0;
         st_more <= 1'b0;
         st_rtry <= 1'b0;
         st_late <= 1'b0;
      end else if (frame_start) begin
         st      <= ST_ARMED;
         dis_r   <= 1'b0;
         late_r  <= 1'b0;
         st_one  <= 1'b0;
         st_more <= 1'b0;
         st_rtry <= 1'b0;
         st_late <= 1'b0;
      end else begin
         unique case (st)
            ST_ARMED: begin
               if (accept) begin
                  if (hit) dis_r <= retry_dis;
                  if (cls == CL_LATE) late_r <= 1'b1;
                  st <= (cls == CL_PRE) ? ST_PEND : ST_JAM;
               end else if (tx_end) begin
                  st_one  <= (retry_cnt == CW'(1));
                  st_more <= (retry_cnt > CW'(1));
                  st      <= ST_FINAL;
               end
            end
            ST_PEND: begin
               if (!pre_phase) st <= ST_JAM;
            end
            ST_JAM: begin
               if (jam_last) begin
                  if (late_r) begin
                     st_late <= 1'b1;
                     st      <= ST_FINAL;
                  end else if (dis_r || exhausted) begin
                     st_rtry <= 1'b1;
                     st      <= ST_FINAL;
                  end else begin
                     st <= ST_BACKOFF;
                  end
               end
            end
            ST_BACKOFF: begin
               if (backoff_done) st <= ST_ARMED;
            end
            ST_FINAL: st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   assign jam_on      = jam_busy;
   assign tx_abort    = jam_first;
   assign resched_req = (st == ST_BACKOFF);
   assign done_stb    = (st == ST_FINAL);
   assign flush_req   = (st == ST_FINAL) && (dis_r || exhausted) && !late_r;

   // R1: a preamble collision keeps the jam off while the preamble continues
   a_r1_hold_in_preamble: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PEND) && pre_phase |=> !jam_on);

   // R4: the reschedule request persists until the backoff answer
   a_r4_resched_hold: assert property (@(posedge clk) disable iff (!rst_n)
      resched_req && !backoff_done && !frame_start |=> resched_req);

   // R3: the abort pulse lasts one cycle
   a_r3_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |=> !tx_abort);

   // R5: a discard request always comes with the exhausted status
   a_r5_flush_has_rtry: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> st_rtry && !st_one && !st_more);

   // R8: a late ending never reports exhausted retries
   a_r8_late_excl: assert property (@(posedge clk) disable iff (!rst_n)
      st_late |-> !st_rtry && !flush_req);

   // R9: a new frame clears the retry count
   a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> retry_cnt == '0 && !st_one && !st_more && !st_rtry && !st_late);

   // R10: the done strobe lasts one cycle
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_stb |=> !done_stb);

endmodule

// File: tb/coll_retry_ctrl_bench.sv
`timescale 1ns/1ps
module coll_retry_ctrl_bench;

   typedef struct packed {
      logic       pre;
      logic [9:0] bits;
      logic [4:0] ncol;
      logic       tail;
      logic       rdis;
      logic       one;
      logic       more;
      logic       rtry;
      logic       late;
      logic [3:0] cnt;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 10'd100, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0},
      '{1'b0, 10'd100, 5'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1},
      '{1'b1, 10'd0,   5'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1},
      '{1'b0, 10'd511, 5'd3,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},
      '{1'b0, 10'd300, 5'd15, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd15},
      '{1'b0, 10'd300, 5'd16, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd15},
      '{1'b0, 10'd50,  5'd1,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1},
      '{1'b0, 10'd512, 5'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0},
      '{1'b0, 10'd200, 5'd3,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},
      '{1'b1, 10'd0,   5'd1,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0, tx_on = 1'b0, pre_phase = 1'b0;
   logic [9:0] data_bits = '0;
   logic coll_det = 1'b0, retry_dis = 1'b0, tx_end = 1'b0, backoff_done = 1'b0;
   logic jam_on, tx_abort, resched_req, flush_req, done_stb;
   logic st_one, st_more, st_rtry, st_late;
   logic [3:0] retry_cnt;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   coll_retry_ctrl u_coll_retry_ctrl (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .tx_on(tx_on),
      .pre_phase(pre_phase), .data_bits(data_bits), .coll_det(coll_det),
      .retry_dis(retry_dis), .tx_end(tx_end), .backoff_done(backoff_done),
      .jam_on(jam_on), .tx_abort(tx_abort), .resched_req(resched_req),
      .flush_req(flush_req), .done_stb(done_stb), .st_one(st_one),
      .st_more(st_more), .st_rtry(st_rtry), .st_late(st_late),
      .retry_cnt(retry_cnt)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_status(input string req, input logic one, input logic more,
                             input logic rtry, input logic late, input logic [3:0] cnt);
      chk({req, " one"},   int'(st_one),    int'(one));
      chk({req, " more"},  int'(st_more),   int'(more));
      chk({req, " rtry"},  int'(st_rtry),   int'(rtry));
      chk({req, " late"},  int'(st_late),   int'(late));
      chk({req, " count"}, int'(retry_cnt), int'(cnt));
   endtask

   task automatic start_frame(input logic rdis);
      @(negedge clk);
      frame_start = 1'b1;
      retry_dis   = rdis;
      @(negedge clk);
      frame_start = 1'b0;
      chk("R9 clear count", int'(retry_cnt), 0);
      chk("R9 clear status", int'({st_one, st_more, st_rtry, st_late}), 0);
   endtask

   // one colliding attempt; returns at the first cycle after the jam
   task automatic collide(input logic pre, input logic [9:0] bits);
      int n;
      tx_on     = 1'b1;
      pre_phase = pre;
      data_bits = bits;
      coll_det  = 1'b1;
      @(negedge clk);
      coll_det = 1'b0;
      if (pre) begin
         for (int k = 0; k < 3; k++) begin
            chk("R1 no jam in preamble", int'(jam_on), 0);
            @(negedge clk);
         end
         pre_phase = 1'b0;
         @(negedge clk);
         chk("R1 jam after preamble", int'(jam_on), 1);
         chk("R1 abort after preamble", int'(tx_abort), 1);
      end else begin
         chk("R2 immediate jam", int'(jam_on), 1);
         chk("R2 immediate abort", int'(tx_abort), 1);
      end
      tx_on = 1'b0;
      n = 0;
      while (jam_on && n < 100) begin
         if (n > 0) chk("R3 abort only first", int'(tx_abort), 0);
         n++;
         @(negedge clk);
      end
      chk("R3 jam length", n, 32);
   endtask

   task automatic backoff();
      chk("R4 resched held", int'(resched_req), 1);
      @(negedge clk);
      chk("R4 resched still held", int'(resched_req), 1);
      backoff_done = 1'b1;
      @(negedge clk);
      backoff_done = 1'b0;
      chk("R4 resched released", int'(resched_req), 0);
   endtask

   task automatic finish_ok();
      tx_on  = 1'b1;
      tx_end = 1'b1;
      @(negedge clk);
      tx_end = 1'b0;
      tx_on  = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset jam", int'(jam_on), 0);
      chk("R10 reset done", int'(done_stb), 0);
      chk_status("R9 reset", 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         automatic vec_t t = VECS[v];
         automatic logic ends_in_jam = t.rtry | t.late;
         start_frame(t.rdis);
         for (int c = 0; c < int'(t.ncol); c++) begin
            automatic logic [9:0] b = (t.tail && c == int'(t.ncol) - 1) ? 10'd600 : t.bits;
            automatic logic lastc = (c == int'(t.ncol) - 1);
            collide(t.pre, b);
            if (lastc && ends_in_jam) begin
               chk("R5 R7 R8 done after jam", int'(done_stb), 1);
               chk("R5 R7 R8 no resched", int'(resched_req), 0);
               chk("R5 R7 flush", int'(flush_req), int'(t.rtry));
            end else begin
               chk("R4 count step", int'(retry_cnt), c + 1);
               backoff();
            end
         end
         if (!ends_in_jam) begin
            finish_ok();
            chk("R6 done strobe", int'(done_stb), 1);
            chk("R6 no flush", int'(flush_req), 0);
         end
         chk_status("R5 R6 R7 R8 status", t.one, t.more, t.rtry, t.late, t.cnt);
         @(negedge clk);
         chk("R10 done one cycle", int'(done_stb), 0);
         chk_status("R10 status held", t.one, t.more, t.rtry, t.late, t.cnt);
      end

      // R11: collision while idle after a finished frame
      tx_on = 1'b1; coll_det = 1'b1; data_bits = 10'd100;
      @(negedge clk);
      coll_det = 1'b0; tx_on = 1'b0;
      chk("R11 idle collision no jam", int'(jam_on), 0);
      chk_status("R11 idle collision", 1'b0, 1'b0, 1'b1, 1'b0, 4'd1);

      // R11: armed but not transmitting
      start_frame(1'b0);
      coll_det = 1'b1;
      @(negedge clk);
      coll_det = 1'b0;
      chk("R11 no tx no jam", int'(jam_on), 0);
      chk("R11 no tx no count", int'(retry_cnt), 0);
      finish_ok();
      chk_status("R11 clean frame", 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);

      // R2 boundary at 511 and R8 boundary at 512 within one frame
      start_frame(1'b0);
      collide(1'b0, 10'd511);
      chk("R2 count at 511", int'(retry_cnt), 1);
      backoff();
      collide(1'b0, 10'd512);
      chk("R8 done at 512", int'(done_stb), 1);
      chk_status("R8 late at 512", 1'b0, 1'b0, 1'b0, 1'b1, 4'd1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule